// File: doc/BRIEF.md
# Configurable UART Serial Engine

This block moves bytes between a parallel byte interface and an asynchronous serial line in both directions. A plain integer divisor turns the system clock into a sample tick. A serial bit spans sixteen sample ticks, or eight when the faster oversampling mode is selected. Control inputs set the frame shape: how many data bits it carries, whether a parity bit follows and what rule sets it, and whether one or two stop bits close it. The transmitter can also hold the line low to signal a break. The receiver recognises an incoming break and reports it.

Each direction uses a single-byte valid/ready handshake. Each received byte is delivered together with its own parity, framing, break and overrun flags. The format inputs are expected to stay constant while a frame is in flight in either direction.

Top module: `uart_eng`

## Requirements
- R1: The sample tick repeats every `divisor` clocks, with a divisor of 0 treated as 1. A serial bit lasts 16 ticks when `hsMode` is 0 and 8 ticks when `hsMode` is 1.
- R2: The transmit line idles high. `txReady` is high only while the transmitter is idle, and a byte is accepted on a clock where `txValid` and `txReady` are both high. The frame that follows is a low start bit, then the data bits least significant first, then the high stop bit or bits. `wordLen` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits, and any unused upper bits of `txData` are ignored.
- R3: When `parEn` is 1, a parity bit follows the data. With `parStick` at 0 it makes the number of ones across data and parity even (`parOdd` at 0) or odd (`parOdd` at 1). With `parStick` at 1 the parity bit is the constant value of `parOdd`.
- R4: The transmitter sends two stop bits when `stopTwo` is 1 and one stop bit when it is 0.
- R5: While `breakTx` is high, `txd` is low whatever the transmitter is doing.
- R6: The receiver confirms a start bit at mid-bit. A low pulse shorter than half a bit produces no byte. Data bits are sampled at their centre and returned right-aligned in `rxData`, with the unused upper bits zero.
- R7: When `parEn` is 1, `rxParErr` is set for a received byte whose parity bit differs from the value R3 defines for its data.
- R8: `rxFrameErr` is set for a byte whose first stop bit is sampled low.
- R9: A frame that is low from the start bit through the stop position is delivered with `rxData` zero and with both `rxBreak` and `rxFrameErr` set. After this, the receiver looks for no new start bit until the line has returned high.
- R10: A delivered byte and its flags hold steady until `rxReady` is high. If a further frame completes while a byte is still held, the new frame is dropped and `rxOverrun` is set on the held byte.
- R11: After reset, `txd` is high, `txReady` is high and `rxValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| divisor | input | DIV_W | Clocks per sample tick |
| hsMode | input | 1 | 1 selects 8 ticks per bit, 0 selects 16 |
| wordLen | input | 2 | Data bit count minus 5 |
| parEn | input | 1 | Parity bit present |
| parOdd | input | 1 | Odd parity, or the constant value in stick mode |
| parStick | input | 1 | Parity bit is a constant |
| stopTwo | input | 1 | Transmit two stop bits |
| breakTx | input | 1 | Force the transmit line low |
| txData | input | 8 | Byte to send |
| txValid | input | 1 | Byte on txData is offered |
| txReady | output | 1 | Transmitter idle, byte can be taken |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line, asynchronous |
| rxData | output | 8 | Received byte, right-aligned |
| rxValid | output | 1 | A received byte is held |
| rxReady | input | 1 | Consumer takes the held byte |
| rxParErr | output | 1 | Parity mismatch on the held byte |
| rxFrameErr | output | 1 | Stop bit of the held byte was low |
| rxBreak | output | 1 | The held byte is a line break |
| rxOverrun | output | 1 | A later frame was dropped while this byte was held |

## Verification
The transmitter is compared cycle by cycle against a bit-queue model for these patterns:
- Alternating and asymmetric data at every word length, which exposes bit order and truncation errors.
- Even, odd and both stick parities, using data with odd and even counts of ones so that each parity rule gives a distinct bit.
- Two stop bits, and a forced break while the line is idle.
- Three divisors, including 1, in both oversampling modes, which separates tick counting from bit counting.

The receiver is driven by a bench-built serial waveform. The cases are:
- Clean frames, and frames with a corrupted parity bit or a low stop bit.
- A long low stretch followed by a normal frame, which shows both break detection and the wait for the line to go high.
- A quarter-bit glitch, which must produce nothing.
- Two frames sent back to back with the consumer stalled, which must keep the first byte and flag the loss of the second.

// File: rtl/uart_eng_pkg.sv
package uart_eng_pkg;

  localparam int DATA_W = 8;

  // what the transmit line carries in the current bit slot
  typedef enum logic [1:0] {
    SEL_MARK  = 2'd0,
    SEL_SPACE = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_PAR   = 2'd3
  } txSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic   txLoad;
    logic   txShift;
    txSel_e txSel;
    logic   rxStart;
    logic   rxBit;
    logic   rxPar;
    logic   rxDone;
  } strobe_t;

  // index of the last data bit: word length code + 4
  function automatic logic [2:0] lastBitIdx(input logic [1:0] wl);
    return {1'b1, wl};
  endfunction

  // 8 minus the data bit count: 3 - code
  function automatic logic [2:0] alignShift(input logic [1:0] wl);
    return {1'b0, ~wl};
  endfunction

  function automatic logic parityOf(input logic [DATA_W-1:0] d,
                                    input logic odd, input logic stick);
    return stick ? odd : ((^d) ^ odd);
  endfunction

endpackage

// File: rtl/uart_eng_baud.sv
module uart_eng_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);

  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] lastPhase;

  assign lastPhase = (divisor == '0) ? '0 : divisor - DIV_W'(1);
  assign tick      = (phase >= lastPhase);

  always_ff @(posedge clk) begin
    if (!rstN)     phase <= '0;
    else if (tick) phase <= '0;
    else           phase <= phase + DIV_W'(1);
  end

endmodule

// File: rtl/uart_eng_ctrl.sv
module uart_eng_ctrl
  import uart_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       hsMode,
  input  logic [1:0] wordLen,
  input  logic       parEn,
  input  logic       stopTwo,
  input  logic       txValid,
  input  logic       rxLine,
  output logic       txReady,
  output strobe_t    strb
);

  typedef enum logic [2:0] {TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP} txSt_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAIT} rxSt_e;

  localparam int TICK_W = 4;

  txSt_e             txSt;
  logic [TICK_W-1:0] txTick;
  logic [2:0]        txBit;
  rxSt_e             rxSt;
  logic [TICK_W-1:0] rxTick;
  logic [2:0]        rxBit;

  logic [TICK_W-1:0] osrLast;
  logic [TICK_W-1:0] startChk;
  logic              txBitEnd;
  logic              rxSample;
  logic              rxChk;

  assign osrLast  = hsMode ? TICK_W'(7) : TICK_W'(15);
  assign startChk = hsMode ? TICK_W'(2) : TICK_W'(6);
  assign txBitEnd = tick && (txTick == osrLast);
  assign rxSample = tick && (rxTick == osrLast);
  assign rxChk    = tick && (rxTick == startChk);

  // transmit sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txSt   <= TX_IDLE;
      txTick <= '0;
      txBit  <= '0;
    end else if (txSt == TX_IDLE) begin
      if (txValid) begin
        txSt   <= TX_START;
        txTick <= '0;
        txBit  <= '0;
      end
    end else if (txBitEnd) begin
      txTick <= '0;
      case (txSt)
        TX_START: begin
          txSt  <= TX_DATA;
          txBit <= '0;
        end
        TX_DATA: begin
          if (txBit == lastBitIdx(wordLen)) begin
            txSt  <= parEn ? TX_PAR : TX_STOP;
            txBit <= '0;
          end else begin
            txBit <= txBit + 3'd1;
          end
        end
        TX_PAR: begin
          txSt  <= TX_STOP;
          txBit <= '0;
        end
        TX_STOP: begin
          if (stopTwo && txBit == 3'd0) txBit <= 3'd1;
          else                          txSt  <= TX_IDLE;
        end
        default: txSt <= TX_IDLE;
      endcase
    end else if (tick) begin
      txTick <= txTick + TICK_W'(1);
    end
  end

  // receive sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSt   <= RX_IDLE;
      rxTick <= '0;
      rxBit  <= '0;
    end else begin
      case (rxSt)
        RX_IDLE: begin
          if (tick && !rxLine) begin
            rxSt   <= RX_START;
            rxTick <= '0;
          end
        end
        RX_START: begin
          if (rxChk) begin
            rxTick <= '0;
            rxBit  <= '0;
            rxSt   <= rxLine ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
        RX_WAIT: begin
          if (tick && rxLine) rxSt <= RX_IDLE;
        end
        default: begin
          if (rxSample) begin
            rxTick <= '0;
            case (rxSt)
              RX_DATA: begin
                if (rxBit == lastBitIdx(wordLen)) rxSt <= parEn ? RX_PAR : RX_STOP;
                else                              rxBit <= rxBit + 3'd1;
              end
              RX_PAR:  rxSt <= RX_STOP;
              default: rxSt <= rxLine ? RX_IDLE : RX_WAIT;
            endcase
          end else if (tick) begin
            rxTick <= rxTick + TICK_W'(1);
          end
        end
      endcase
    end
  end

  always_comb begin
    strb         = '0;
    strb.txLoad  = (txSt == TX_IDLE) && txValid;
    strb.txShift = (txSt == TX_DATA) && txBitEnd;
    case (txSt)
      TX_START: strb.txSel = SEL_SPACE;
      TX_DATA:  strb.txSel = SEL_DATA;
      TX_PAR:   strb.txSel = SEL_PAR;
      default:  strb.txSel = SEL_MARK;
    endcase
    strb.rxStart = (rxSt == RX_START) && rxChk && !rxLine;
    strb.rxBit   = (rxSt == RX_DATA) && rxSample;
    strb.rxPar   = (rxSt == RX_PAR) && rxSample;
    strb.rxDone  = (rxSt == RX_STOP) && rxSample;
  end

  assign txReady = (txSt == TX_IDLE);

endmodule

// File: rtl/uart_eng_dp.sv
module uart_eng_dp
  import uart_eng_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [1:0]        wordLen,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              parStick,
  input  logic              breakTx,
  input  logic [DATA_W-1:0] txData,
  input  logic              rxd,
  input  logic              rxReady,
  output logic              txd,
  output logic              rxLine,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak,
  output logic              rxOverrun
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_W-1:0]      wordMask;
  logic [DATA_W-1:0]      txShreg;
  logic                   txPar;
  logic                   lineBit;
  logic [DATA_W-1:0]      rxShreg;
  logic                   rxParSeen;
  logic                   anyHigh;
  logic [DATA_W-1:0]      rxWord;
  logic                   newParErr;

  // input synchroniser, idles at mark
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxd};
  end
  assign rxLine = syncQ[SYNC_STAGES-1];

  assign wordMask = {DATA_W{1'b1}} >> alignShift(wordLen);

  // transmit data path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShreg <= '0;
      txPar   <= 1'b0;
    end else if (strb.txLoad) begin
      txShreg <= txData & wordMask;
      txPar   <= parityOf(txData & wordMask, parOdd, parStick);
    end else if (strb.txShift) begin
      txShreg <= txShreg >> 1;
    end
  end

  always_comb begin
    case (strb.txSel)
      SEL_SPACE: lineBit = 1'b0;
      SEL_DATA:  lineBit = txShreg[0];
      SEL_PAR:   lineBit = txPar;
      default:   lineBit = 1'b1;
    endcase
  end
  assign txd = lineBit & ~breakTx;

  // receive data path
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShreg   <= '0;
      rxParSeen <= 1'b0;
      anyHigh   <= 1'b0;
    end else if (strb.rxStart) begin
      rxShreg <= '0;
      anyHigh <= 1'b0;
    end else if (strb.rxBit) begin
      rxShreg <= {rxLine, rxShreg[DATA_W-1:1]};
      anyHigh <= anyHigh | rxLine;
    end else if (strb.rxPar) begin
      rxParSeen <= rxLine;
      anyHigh   <= anyHigh | rxLine;
    end
  end

  assign rxWord    = rxShreg >> alignShift(wordLen);
  assign newParErr = parEn && (rxParSeen != parityOf(rxWord, parOdd, parStick));

  // holding register toward the consumer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid    <= 1'b0;
      rxData     <= '0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
      rxBreak    <= 1'b0;
      rxOverrun  <= 1'b0;
    end else if (strb.rxDone) begin
      if (rxValid && !rxReady) begin
        rxOverrun <= 1'b1;
      end else begin
        rxValid    <= 1'b1;
        rxData     <= rxWord;
        rxParErr   <= newParErr;
        rxFrameErr <= !rxLine;
        rxBreak    <= !rxLine && !anyHigh;
        rxOverrun  <= 1'b0;
      end
    end else if (rxValid && rxReady) begin
      rxValid   <= 1'b0;
      rxOverrun <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_eng.sv
module uart_eng
  import uart_eng_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divisor,
  input  logic              hsMode,
  input  logic [1:0]        wordLen,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              parStick,
  input  logic              stopTwo,
  input  logic              breakTx,
  input  logic [DATA_W-1:0] txData,
  input  logic              txValid,
  output logic              txReady,
  output logic              txd,
  input  logic              rxd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxValid,
  input  logic              rxReady,
  output logic              rxParErr,
  output logic              rxFrameErr,
  output logic              rxBreak,
  output logic              rxOverrun
);

  logic    tick;
  logic    rxLine;
  strobe_t strb;

  uart_eng_baud #(.DIV_W(DIV_W)) baud_i (
    .clk     (clk),
    .rstN    (rstN),
    .divisor (divisor),
    .tick    (tick)
  );

  uart_eng_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .hsMode  (hsMode),
    .wordLen (wordLen),
    .parEn   (parEn),
    .stopTwo (stopTwo),
    .txValid (txValid),
    .rxLine  (rxLine),
    .txReady (txReady),
    .strb    (strb)
  );

  uart_eng_dp #(.SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordLen    (wordLen),
    .parEn      (parEn),
    .parOdd     (parOdd),
    .parStick   (parStick),
    .breakTx    (breakTx),
    .txData     (txData),
    .rxd        (rxd),
    .rxReady    (rxReady),
    .txd        (txd),
    .rxLine     (rxLine),
    .rxData     (rxData),
    .rxValid    (rxValid),
    .rxParErr   (rxParErr),
    .rxFrameErr (rxFrameErr),
    .rxBreak    (rxBreak),
    .rxOverrun  (rxOverrun)
  );

endmodule

// File: rtl/uart_eng_chk.sv
module uart_eng_chk (
  input logic       clk,
  input logic       rstN,
  input logic       breakTx,
  input logic       txValid,
  input logic       txReady,
  input logic       txd,
  input logic [7:0] rxData,
  input logic       rxValid,
  input logic       rxReady,
  input logic       rxFrameErr,
  input logic       rxBreak,
  input logic       rxOverrun
);

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rstN)
    (txReady && !breakTx) |-> txd) else $error("idle line not high"); // R2

  AST_START_SPACE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!txd || breakTx)) else $error("no start bit"); // R2

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> !txReady) else $error("ready after accept"); // R2

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rxReady) |=> (rxValid && $stable(rxData))) else $error("held byte moved"); // R10

  AST_OVR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rxOverrun |-> rxValid) else $error("overrun without byte"); // R10

  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxBreak) |-> (rxFrameErr && rxData == 8'h00)) else $error("break flags"); // R9

endmodule

bind uart_eng uart_eng_chk chk_i (.*);

// File: tb/uart_eng_tb_top.sv
module uart_eng_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divisor = 16'd4;
  logic        hsMode = 1'b0;
  logic [1:0]  wordLen = 2'd3;
  logic        parEn = 1'b0, parOdd = 1'b0, parStick = 1'b0, stopTwo = 1'b0;
  logic        breakTx = 1'b0;
  logic [7:0]  txData = 8'h00;
  logic        txValid = 1'b0;
  logic        txReady, txd;
  logic        rxd = 1'b1;
  logic [7:0]  rxData;
  logic        rxValid;
  logic        rxReady = 1'b1;
  logic        rxParErr, rxFrameErr, rxBreak, rxOverrun;

  int vecCnt = 0;
  int missCnt = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  uart_eng dut_i (
    .clk(clk), .rstN(rstN), .divisor(divisor), .hsMode(hsMode), .wordLen(wordLen),
    .parEn(parEn), .parOdd(parOdd), .parStick(parStick), .stopTwo(stopTwo),
    .breakTx(breakTx), .txData(txData), .txValid(txValid), .txReady(txReady),
    .txd(txd), .rxd(rxd), .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .rxBreak(rxBreak), .rxOverrun(rxOverrun)
  );

  function automatic int osrNow();
    return hsMode ? 8 : 16;
  endfunction

  function automatic int divNow();
    return (divisor == 16'd0) ? 1 : int'(divisor);
  endfunction

  function automatic bit calcPar(logic [7:0] d, int nb, bit odd, bit stick);
    bit p;
    if (stick) return odd;
    p = odd;
    for (int i = 0; i < nb; i++) p ^= d[i];
    return p;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    vecCnt++;
    if (!ok) begin
      missCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // transmit reference: a queue of line levels, one per bit slot
  int mPh = 0, mTicks = 0;
  bit mBusy = 0;
  bit mQ[$];

  always @(posedge clk) begin
    int  nb;
    bit  mTick;
    if (!rstN) begin
      mPh = 0; mBusy = 0; mTicks = 0; mQ.delete();
    end else begin
      mTick = (mPh >= divNow() - 1);
      mPh   = mTick ? 0 : mPh + 1;
      if (mBusy) begin
        if (mTick) begin
          mTicks++;
          if (mTicks == osrNow()) begin
            mTicks = 0;
            void'(mQ.pop_front());
            if (mQ.size() == 0) mBusy = 0;
          end
        end
      end else if (txValid) begin
        nb = 5 + int'(wordLen);
        mQ.push_back(1'b0);
        for (int i = 0; i < nb; i++) mQ.push_back(txData[i]);
        if (parEn) mQ.push_back(calcPar(txData, nb, parOdd, parStick));
        mQ.push_back(1'b1);
        if (stopTwo) mQ.push_back(1'b1);
        mBusy = 1; mTicks = 0;
      end
    end
  end

  typedef struct {
    logic [7:0] d;
    bit pe, fe, br, ov;
  } rxRec_t;
  rxRec_t rxQ[$];

  // per-cycle comparison, a little after the falling edge
  always @(negedge clk) begin
    bit     expTx;
    rxRec_t e;
    #1;
    if (rstN) begin
      expTx = (mBusy ? mQ[0] : 1'b1) & !breakTx;
      chk(txd === expTx, breakTx ? "R5" : "R2", "txd", int'(txd), int'(expTx));
      chk(txReady === !mBusy, "R2", "txReady", int'(txReady), int'(!mBusy));
      if (rxValid && rxReady) begin
        if (rxQ.size() == 0) begin
          chk(0, "R6", "unexpected byte", int'(rxData), 0);
        end else begin
          e = rxQ.pop_front();
          chk(rxData === e.d, "R6", "rxData", int'(rxData), int'(e.d));
          chk(rxParErr === e.pe, "R7", "rxParErr", int'(rxParErr), int'(e.pe));
          chk(rxFrameErr === e.fe, "R8", "rxFrameErr", int'(rxFrameErr), int'(e.fe));
          chk(rxBreak === e.br, "R9", "rxBreak", int'(rxBreak), int'(e.br));
          chk(rxOverrun === e.ov, "R10", "rxOverrun", int'(rxOverrun), int'(e.ov));
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      missCnt++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  task automatic sendTx(logic [7:0] d);
    @(negedge clk);
    while (!txReady) @(negedge clk);
    txData = d; txValid = 1'b1;
    @(negedge clk);
    txValid = 1'b0;
    while (!txReady) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  task automatic driveBit(bit b, int nbits);
    rxd = b;
    repeat (nbits * osrNow() * divNow()) @(negedge clk);
  endtask

  task automatic sendRx(logic [7:0] d, bit badPar, bit stopLow, bit push);
    rxRec_t e;
    int nb;
    nb = 5 + int'(wordLen);
    e.d  = d & (8'hFF >> (3 - int'(wordLen)));
    e.pe = parEn && badPar;
    e.fe = stopLow;
    e.br = 0;
    e.ov = 0;
    if (push) rxQ.push_back(e);
    driveBit(1'b0, 1);
    for (int i = 0; i < nb; i++) driveBit(d[i], 1);
    if (parEn) driveBit(calcPar(d, nb, parOdd, parStick) ^ badPar, 1);
    driveBit(!stopLow, 1);
    driveBit(1'b1, 2);
  endtask

  initial begin
    rxRec_t e;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R11 reset state
    chk(txd === 1'b1, "R11", "txd", int'(txd), 1);
    chk(txReady === 1'b1, "R11", "txReady", int'(txReady), 1);
    chk(rxValid === 1'b0, "R11", "rxValid", int'(rxValid), 0);

    // R2 plain 8-bit frames, R1 at divisor 4 and 16x
    sendTx(8'hA5);
    sendTx(8'h3C);
    // R3 even, odd, stick-odd, stick-even parity
    parEn = 1;
    sendTx(8'h5A);
    parOdd = 1; sendTx(8'h5B);
    parStick = 1; sendTx(8'h00);
    parOdd = 0; sendTx(8'hFF);
    parStick = 0; parEn = 0;
    // R4 two stop bits at 7 data bits
    stopTwo = 1; wordLen = 2'd2; sendTx(8'h81);
    stopTwo = 0;
    // R2 5- and 6-bit words ignore upper bits
    wordLen = 2'd0; sendTx(8'hFF);
    wordLen = 2'd1; sendTx(8'hD2);
    wordLen = 2'd3;
    // R1 8x mode and a divisor of 1
    hsMode = 1; divisor = 16'd3; sendTx(8'h96);
    divisor = 16'd1; sendTx(8'h69);
    hsMode = 0; divisor = 16'd4;
    // R5 forced break
    breakTx = 1; repeat (100) @(negedge clk);
    breakTx = 0; repeat (10) @(negedge clk);

    // R6 receive, several widths and both sample rates
    sendRx(8'hC3, 0, 0, 1);
    sendRx(8'h01, 0, 0, 1);
    wordLen = 2'd0; sendRx(8'hEA, 0, 0, 1);
    wordLen = 2'd3;
    hsMode = 1; divisor = 16'd3; sendRx(8'h5E, 0, 0, 1);
    hsMode = 0; divisor = 16'd4;
    // R7 parity check
    parEn = 1;
    sendRx(8'h3C, 0, 0, 1);
    sendRx(8'h3C, 1, 0, 1);
    parOdd = 1; parStick = 1; sendRx(8'h42, 1, 0, 1);
    parOdd = 0; parStick = 0; parEn = 0;
    // R8 low stop bit
    sendRx(8'h55, 0, 1, 1);
    // R9 break, then a normal frame once the line is high again
    e.d = 8'h00; e.pe = 0; e.fe = 1; e.br = 1; e.ov = 0;
    rxQ.push_back(e);
    driveBit(1'b0, 12);
    driveBit(1'b1, 2);
    sendRx(8'h77, 0, 0, 1);
    // R6 short glitch gives no byte
    rxd = 1'b0;
    repeat (osrNow() * divNow() / 4) @(negedge clk);
    driveBit(1'b1, 2);
    chk(rxValid === 1'b0, "R6", "glitch rxValid", int'(rxValid), 0);
    // R10 overrun with stalled consumer
    rxReady = 0;
    sendRx(8'h11, 0, 0, 0);
    sendRx(8'h22, 0, 0, 0);
    chk(rxValid === 1'b1, "R10", "held rxValid", int'(rxValid), 1);
    chk(rxData === 8'h11, "R10", "held rxData", int'(rxData), 8'h11);
    chk(rxOverrun === 1'b1, "R10", "rxOverrun", int'(rxOverrun), 1);
    e.d = 8'h11; e.pe = 0; e.fe = 0; e.br = 0; e.ov = 1;
    rxQ.push_back(e);
    rxReady = 1;
    repeat (5) @(negedge clk);
    chk(rxValid === 1'b0, "R10", "rxValid after take", int'(rxValid), 0);
    chk(rxQ.size() == 0, "R6", "bytes missing", rxQ.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule